// File: doc/BRIEF.md
# Two-Controller Graphic LCD Access Sequencer

This block sits between a processor's register port and a 128x64 monochrome graphic LCD module. The module's screen is split into a left half and a right half, each run by its own column controller. The two controllers share one 8-bit bidirectional data bus and the RS, R/W and E strobes, and each has its own chip-select line. Software loads a page number, a column number and a data word into registers. It then writes an operation code to the control register. The block carries out the whole bus transaction on its own and reports when it has finished.

Each request starts with status reads of the addressed controller. The block repeats the status read until the controller's busy flag is clear. Only then does it make the real access: a command byte, a display-data write, a display-data read or a status read. The three timing phases have fixed lengths in clock cycles: address setup, E high, and one cycle of hold after E falls. Both the setup and E-high lengths are parameters, so that each can be set to at least 450 ns at the system clock.

The register port is a plain single-cycle read/write port with no back-pressure. Every write to it takes effect at once. A request written while the block is busy is dropped, and software learns the state from the status bits. The block has no valid/ready stream interface, because no data flows through it continuously.

Top module: `glcd_sequencer`

## Requirements
- R1: The register map is: offset 0 is the page register (8 bits), offset 1 is the column register (8 bits), offset 2 is the data register (32 bits), and offset 3 is control on write and status on read. The page, column and data registers read back what was last written, with the unused upper bits reading as zero.
- R2: A write to offset 3 with value bits [2:0] as the operation code starts a request. The codes are: 1 = display on/off, which sends 0x3E OR data[0]; 2 = start line, which sends 0xC0 OR data[5:0]; 3 = set page, which sends 0xB8 OR page[2:0]; 4 = set column, which sends 0x40 OR column[5:0]. These four are command writes with RS=0 and R/W=0.
- R3: When column register bit 6 is 0, the request asserts lcd_cs1 only. When it is 1, the request asserts lcd_cs2 only. The set-column command carries column[5:0], so column 100 becomes controller column 36. Both chip selects are low (active high) between accesses.
- R4: Before its access, every request reads the addressed controller's status (RS=0, R/W=1). It repeats that read while status bit 7 (busy) is 1, and it makes the access only after a read with bit 7 equal to 0.
- R5: Operation code 5 writes data[7:0] as display data with RS=1 and R/W=0. The byte stays driven on lcd_db through the falling edge of E and for one cycle after it.
- R6: Operation code 6 reads display data (RS=1, R/W=1). Operation code 7 reads status (RS=0, R/W=1). Either one stores the byte sampled in the last E-high cycle into data register bits [7:0], and clears bits [31:8].
- R7: RS, R/W and the chip selects are stable for at least SETUP_CYC cycles before E rises, and they stay unchanged while E is high. E stays high for exactly EHIGH_CYC cycles and is low outside accesses.
- R8: The block never drives lcd_db while R/W is high.
- R9: In the status word, bit 0 is busy: it is 1 from the cycle after an accepted request until the request completes. Bit 1 is done: it is set when a request completes and cleared when a new request is accepted.
- R10: A request written while busy is 1 is ignored, and so is operation code 0. Neither one causes any panel access or changes the data register.
- R11: lcd_rst_n is low while the block is in reset and goes high in the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register offset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for cpu_addr |
| lcd_db | inout | 8 | Panel data bus |
| lcd_cs1 | output | 1 | Left-half controller select, active high |
| lcd_cs2 | output | 1 | Right-half controller select, active high |
| lcd_rs | output | 1 | 1 = display data, 0 = command/status |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_e | output | 1 | Access enable strobe |
| lcd_rst_n | output | 1 | Panel reset, active low |

## Verification
The bench connects a behavioural model of the two controllers. The model decodes command bytes on the falling edge of E and serves display data and status while E is high, and it can report busy for a chosen number of polls.

Commands are sent to both halves, using columns on each side of 64, to show whether chip-select steering and the 6-bit column field are correct. Writes followed by reads at a preloaded location show whether the byte direction and the RS level are right. A controller held busy for several polls shows whether the block waits for a clear status before the access.

Requests made while the block is busy, and a zero operation code, show whether stray control writes can start accesses. The model also checks the setup time, the E width and the release of the bus on every strobe.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_DISP  = 3'd1,
    OP_LINE  = 3'd2,
    OP_PAGE  = 3'd3,
    OP_COL   = 3'd4,
    OP_WDATA = 3'd5,
    OP_RDATA = 3'd6,
    OP_RSTAT = 3'd7
  } glcd_op_e;

  typedef struct packed {
    logic       rs;
    logic       rw;
    logic       cs2;
    logic [7:0] dat;
  } glcd_acc_t;

  localparam logic [1:0] REG_PAGE = 2'd0;
  localparam logic [1:0] REG_COL  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;
  localparam int         BUSY_BIT = 7;

  // Build the bus access for one requested operation.
  function automatic glcd_acc_t make_access(glcd_op_e op, logic [2:0] page,
                                            logic [6:0] col, logic [7:0] dat);
    glcd_acc_t a;
    a.cs2 = col[6];
    a.rs  = 1'b0;
    a.rw  = 1'b0;
    a.dat = 8'h00;
    case (op)
      OP_DISP:  a.dat = {7'b0011111, dat[0]};
      OP_LINE:  a.dat = {2'b11, dat[5:0]};
      OP_PAGE:  a.dat = {5'b10111, page};
      OP_COL:   a.dat = {2'b01, col[5:0]};
      OP_WDATA: begin a.rs = 1'b1; a.dat = dat; end
      OP_RDATA: begin a.rs = 1'b1; a.rw = 1'b1; end
      OP_RSTAT: a.rw = 1'b1;
      default:  a.dat = 8'h00;
    endcase
    return a;
  endfunction

  function automatic glcd_acc_t status_access(logic cs2);
    glcd_acc_t a;
    a.cs2 = cs2;
    a.rs  = 1'b0;
    a.rw  = 1'b1;
    a.dat = 8'h00;
    return a;
  endfunction

endpackage

// File: rtl/glcd_timing.sv
module glcd_timing
  import glcd_pkg::*;
#(
  parameter int SETUP_CYC = 57,
  parameter int EHIGH_CYC = 57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  glcd_acc_t  acc,
  input  logic [7:0] db_in,
  output logic       e,
  output logic       rs,
  output logic       rw,
  output logic       cs1,
  output logic       cs2,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic [7:0] rd_byte,
  output logic       done
);
  localparam int CNT_MAX = (SETUP_CYC > EHIGH_CYC) ? SETUP_CYC : EHIGH_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] EHIGH_LAST = CW'(EHIGH_CYC - 1);

  typedef enum logic [1:0] {T_IDLE, T_SETUP, T_EHI, T_HOLD} tstate_e;

  tstate_e       st;
  logic [CW-1:0] cnt;
  glcd_acc_t     cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      cnt     <= '0;
      cur     <= '{rs: 1'b0, rw: 1'b1, cs2: 1'b0, dat: 8'h00};
      rd_byte <= 8'h00;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          cur <= acc;
          cnt <= '0;
          st  <= T_SETUP;
        end
        T_SETUP: begin
          if (cnt == SETUP_LAST) begin
            cnt <= '0;
            st  <= T_EHI;
          end else cnt <= cnt + 1'b1;
        end
        T_EHI: begin
          if (cnt == EHIGH_LAST) begin
            rd_byte <= db_in;
            cnt     <= '0;
            st      <= T_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          done <= 1'b1;
          st   <= T_IDLE;
        end
      endcase
    end
  end

  logic active;
  assign active = (st != T_IDLE);
  assign e      = (st == T_EHI);
  assign rs     = active & cur.rs;
  assign rw     = active ? cur.rw : 1'b1;
  assign cs1    = active & ~cur.cs2;
  assign cs2    = active & cur.cs2;
  assign db_oe  = active & ~cur.rw;
  assign db_out = cur.dat;

  a_r7_ctrl_stable_in_e: assert property (@(posedge clk) disable iff (!rst_n)
    (e && $past(e)) |-> ($stable(rs) && $stable(rw) && $stable(cs1) && $stable(cs2)));
  a_r3_one_select_in_e: assert property (@(posedge clk) disable iff (!rst_n)
    e |-> (cs1 ^ cs2));
  a_r7_e_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e) |-> ($past(cs1) || $past(cs2)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
  import glcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  glcd_op_e   req_op,
  input  logic [2:0] page,
  input  logic [6:0] col,
  input  logic [7:0] dat,
  output logic       t_start,
  output glcd_acc_t  t_acc,
  input  logic       t_done,
  input  logic [7:0] t_rd_byte,
  output logic       busy,
  output logic       done,
  output logic       res_valid,
  output logic [7:0] res_byte
);
  typedef enum logic [2:0] {C_IDLE, C_POLL, C_PWAIT, C_ACC, C_AWAIT} cstate_e;

  cstate_e   st;
  glcd_acc_t acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      acc_q     <= '0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_byte  <= 8'h00;
    end else begin
      done      <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        C_IDLE: if (req && req_op != OP_NONE) begin
          acc_q <= make_access(req_op, page, col, dat);
          st    <= C_POLL;
        end
        C_POLL:  st <= C_PWAIT;
        C_PWAIT: if (t_done) st <= t_rd_byte[BUSY_BIT] ? C_POLL : C_ACC;
        C_ACC:   st <= C_AWAIT;
        default: if (t_done) begin
          done      <= 1'b1;
          res_valid <= acc_q.rw;
          res_byte  <= t_rd_byte;
          st        <= C_IDLE;
        end
      endcase
    end
  end

  assign busy    = (st != C_IDLE);
  assign t_start = (st == C_POLL) || (st == C_ACC);
  assign t_acc   = (st == C_POLL) ? status_access(acc_q.cs2) : acc_q;

  a_r4_access_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACC) |-> ($past(st) == C_PWAIT && !$past(t_rd_byte[BUSY_BIT])));
  a_r10_request_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_IDLE && $past(st) != C_IDLE) |-> $stable(acc_q));
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/glcd_regs.sv
module glcd_regs
  import glcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cpu_addr,
  input  logic        cpu_wr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  input  logic        busy,
  input  logic        done,
  input  logic        res_valid,
  input  logic [7:0]  res_byte,
  output logic [7:0]  page_q,
  output logic [7:0]  col_q,
  output logic [31:0] data_q,
  output logic        req,
  output glcd_op_e    req_op
);
  logic done_flag;
  logic accept;

  assign req    = cpu_wr && (cpu_addr == REG_CTRL) && !busy;
  assign req_op = glcd_op_e'(cpu_wdata[2:0]);
  assign accept = req && (req_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= 8'h00;
      col_q     <= 8'h00;
      data_q    <= 32'h0;
      done_flag <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == REG_PAGE) page_q <= cpu_wdata[7:0];
      if (cpu_wr && cpu_addr == REG_COL)  col_q  <= cpu_wdata[7:0];
      if (res_valid)                          data_q <= {24'h0, res_byte};
      else if (cpu_wr && cpu_addr == REG_DATA) data_q <= cpu_wdata;
      if (done)        done_flag <= 1'b1;
      else if (accept) done_flag <= 1'b0;
    end
  end

  always_comb begin
    case (cpu_addr)
      REG_PAGE: cpu_rdata = {24'h0, page_q};
      REG_COL:  cpu_rdata = {24'h0, col_q};
      REG_DATA: cpu_rdata = data_q;
      default:  cpu_rdata = {30'h0, done_flag, busy};
    endcase
  end

  a_r10_no_read_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
endmodule

// File: rtl/glcd_sequencer.sv
module glcd_sequencer
  import glcd_pkg::*;
#(
  parameter int SETUP_CYC = 57,
  parameter int EHIGH_CYC = 57
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cpu_addr,
  input  logic        cpu_wr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  inout  wire  [7:0]  lcd_db,
  output logic        lcd_cs1,
  output logic        lcd_cs2,
  output logic        lcd_rs,
  output logic        lcd_rw,
  output logic        lcd_e,
  output logic        lcd_rst_n
);
  logic [7:0]  page_q, col_q;
  logic [31:0] data_q;
  logic        req, busy, done, res_valid;
  glcd_op_e    req_op;
  logic [7:0]  res_byte;
  logic        t_start, t_done;
  glcd_acc_t   t_acc;
  logic [7:0]  t_rd_byte, db_out;
  logic        db_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcd_rst_n <= 1'b0;
    else        lcd_rst_n <= 1'b1;
  end

  glcd_regs u_regs (
    .clk, .rst_n, .cpu_addr, .cpu_wr, .cpu_wdata, .cpu_rdata,
    .busy, .done, .res_valid, .res_byte,
    .page_q, .col_q, .data_q, .req, .req_op
  );

  glcd_ctrl u_ctrl (
    .clk, .rst_n, .req, .req_op,
    .page(page_q[2:0]), .col(col_q[6:0]), .dat(data_q[7:0]),
    .t_start, .t_acc, .t_done, .t_rd_byte,
    .busy, .done, .res_valid, .res_byte
  );

  glcd_timing #(.SETUP_CYC(SETUP_CYC), .EHIGH_CYC(EHIGH_CYC)) u_timing (
    .clk, .rst_n, .start(t_start), .acc(t_acc), .db_in(lcd_db),
    .e(lcd_e), .rs(lcd_rs), .rw(lcd_rw), .cs1(lcd_cs1), .cs2(lcd_cs2),
    .db_out, .db_oe, .rd_byte(t_rd_byte), .done(t_done)
  );

  assign lcd_db = db_oe ? db_out : 8'hzz;

  a_r8_bus_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !db_oe);
  a_r11_panel_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lcd_rst_n);
endmodule

// File: tb/tb_glcd_sequencer.sv
module tb_glcd_sequencer;
  localparam int SETUP = 6;
  localparam int EHI   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = 32'h0;
  logic [31:0] cpu_rdata;
  wire  [7:0]  lcd_db;
  logic        lcd_cs1, lcd_cs2, lcd_rs, lcd_rw, lcd_e, lcd_rst_n;

  always #4 clk = ~clk;

  glcd_sequencer #(.SETUP_CYC(SETUP), .EHIGH_CYC(EHI)) dut (
    .clk, .rst_n, .cpu_addr, .cpu_wr, .cpu_wdata, .cpu_rdata,
    .lcd_db, .lcd_cs1, .lcd_cs2, .lcd_rs, .lcd_rw, .lcd_e, .lcd_rst_n
  );

  // ---------------- panel model ----------------
  logic [7:0] ram [2][512];
  logic       m_on [2];
  logic [5:0] m_line [2];
  logic [2:0] m_page [2];
  logic [5:0] m_col [2];
  int         busy_left [2];
  int         busy_n = 0;
  int         acc_cnt = 0, poll_cnt = 0, polls_since = 0, last_polls = 0;
  int         viol = 0, z_viol = 0, order_viol = 0;
  logic       last_poll_busy = 1'b1;
  logic [3:0] prev_ctl = 4'b0100;
  logic       prev_e = 1'b0;
  int         stable = 0, ehi_cnt = 0;

  logic       mdl_drv;
  logic       idx;
  logic [7:0] mdl_byte;
  assign idx      = lcd_cs2;
  assign mdl_drv  = lcd_e && lcd_rw && (lcd_cs1 ^ lcd_cs2);
  assign mdl_byte = lcd_rs ? ram[idx][{m_page[idx], m_col[idx]}]
                           : {busy_left[idx] > 0, 1'b0, ~m_on[idx], 5'b0};
  assign lcd_db   = mdl_drv ? mdl_byte : 8'hzz;

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_on[c] = 1'b0; m_line[c] = '0; m_page[c] = '0; m_col[c] = '0; busy_left[c] = 0;
      for (int a = 0; a < 512; a++) ram[c][a] = 8'h00;
    end
  end

  always @(negedge clk) begin
    logic [3:0] ctl;
    ctl = {lcd_rs, lcd_rw, lcd_cs1, lcd_cs2};
    if (ctl != prev_ctl) stable = 0; else stable++;
    prev_ctl = ctl;
    if (lcd_rw && !mdl_drv && lcd_db !== 8'hzz) z_viol++;
    if (lcd_e && !prev_e && stable < SETUP) viol++;
    if (lcd_e) ehi_cnt++;
    if (!lcd_e && prev_e) begin
      if (ehi_cnt != EHI) viol++;
      ehi_cnt = 0;
      if (!lcd_rw) begin
        if (polls_since == 0 || last_poll_busy) order_viol++;
        last_polls = polls_since; polls_since = 0; acc_cnt++;
        if (lcd_rs) begin
          ram[idx][{m_page[idx], m_col[idx]}] = lcd_db;
          m_col[idx] = m_col[idx] + 6'd1;
        end else if (lcd_db[7:1] == 7'b0011111) m_on[idx] = lcd_db[0];
        else if (lcd_db[7:6] == 2'b11)          m_line[idx] = lcd_db[5:0];
        else if (lcd_db[7:3] == 5'b10111)       m_page[idx] = lcd_db[2:0];
        else if (lcd_db[7:6] == 2'b01)          m_col[idx] = lcd_db[5:0];
        busy_left[idx] = busy_n;
      end else if (lcd_rs) begin
        if (polls_since == 0 || last_poll_busy) order_viol++;
        last_polls = polls_since; polls_since = 0; acc_cnt++;
        m_col[idx] = m_col[idx] + 6'd1;
      end else begin
        poll_cnt++; polls_since++;
        last_poll_busy = (busy_left[idx] > 0);
        if (busy_left[idx] > 0) busy_left[idx]--;
      end
    end
    prev_e = lcd_e;
  end

  // ---------------- bench helpers ----------------
  int nchk = 0, nfail = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [31:0] s;
    int n = 0;
    do begin cpu_read(2'd3, s); n++; end while (s[0] && n < 3000);
    check({tag, " completes"}, {31'h0, s[0]}, 32'h0);
  endtask

  task automatic run_op(logic [2:0] op, string tag);
    cpu_write(2'd3, {29'h0, op});
    wait_idle(tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    check("R11 rst out low in reset", {31'h0, lcd_rst_n}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 rst out high", {31'h0, lcd_rst_n}, 32'h1);
    check("R7 E low idle", {31'h0, lcd_e}, 32'h0);
    check("R3 selects idle", {30'h0, lcd_cs1, lcd_cs2}, 32'h0);
    check("R8 rw high idle", {31'h0, lcd_rw}, 32'h1);
    cpu_read(2'd3, s);
    check("R9 status reset", s, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    cpu_write(2'd0, 32'hFFFF_FF05);
    cpu_write(2'd1, 32'h0000_0147);
    cpu_write(2'd2, 32'hDEAD_BEEF);
    cpu_read(2'd0, v); check("R1 page readback", v, 32'h05);
    cpu_read(2'd1, v); check("R1 col readback", v, 32'h47);
    cpu_read(2'd2, v); check("R1 data readback", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_display();
    cpu_write(2'd1, 32'd0);
    cpu_write(2'd2, 32'h1);
    run_op(3'd1, "R2 disp on left");
    check("R3 left on", {31'h0, m_on[0]}, 32'h1);
    check("R3 right untouched", {31'h0, m_on[1]}, 32'h0);
    check("R4 one clear poll", last_polls, 1);
    cpu_write(2'd1, 32'd64);
    run_op(3'd1, "R2 disp on right");
    check("R3 right on", {31'h0, m_on[1]}, 32'h1);
    cpu_write(2'd1, 32'd10);
    cpu_write(2'd2, 32'h0);
    run_op(3'd1, "R2 disp off left");
    check("R2 left off", {31'h0, m_on[0]}, 32'h0);
  endtask

  task automatic t_addr();
    cpu_write(2'd1, 32'd100);
    cpu_write(2'd2, 32'h2A);
    run_op(3'd2, "R2 line");
    check("R2 start line right", {26'h0, m_line[1]}, 32'h2A);
    cpu_write(2'd0, 32'd6);
    run_op(3'd3, "R2 page");
    check("R2 page right", {29'h0, m_page[1]}, 32'd6);
    run_op(3'd4, "R2 col");
    check("R3 col field 100", {26'h0, m_col[1]}, 32'd36);
    cpu_write(2'd1, 32'd63);
    run_op(3'd4, "R2 col left");
    check("R3 col 63 left", {26'h0, m_col[0]}, 32'd63);
  endtask

  task automatic t_write();
    int c0;
    cpu_write(2'd0, 32'd2);
    cpu_write(2'd1, 32'd70);
    run_op(3'd3, "R5 page");
    run_op(3'd4, "R5 col");
    cpu_write(2'd2, 32'h1234_5A6B);
    c0 = acc_cnt;
    run_op(3'd5, "R5 wdata");
    check("R5 ram byte", {24'h0, ram[1][2*64+6]}, 32'h6B);
    check("R5 one access", acc_cnt, c0 + 1);
  endtask

  task automatic t_read();
    logic [31:0] v;
    ram[0][4*64+9] = 8'hC3;
    cpu_write(2'd0, 32'd4);
    cpu_write(2'd1, 32'd9);
    run_op(3'd3, "R6 page");
    run_op(3'd4, "R6 col");
    cpu_write(2'd2, 32'hFFFF_FFFF);
    run_op(3'd6, "R6 rdata");
    cpu_read(2'd2, v);
    check("R6 read byte", v, 32'h0000_00C3);
    run_op(3'd7, "R6 rstat");
    cpu_read(2'd2, v);
    check("R6 status byte off", v, 32'h0000_0020);
  endtask

  task automatic t_busy();
    busy_n = 3;
    cpu_write(2'd1, 32'd5);
    cpu_write(2'd2, 32'h77);
    run_op(3'd5, "R4 prime");
    run_op(3'd5, "R4 held");
    check("R4 polls until clear", last_polls, 4);
    busy_n = 0;
    run_op(3'd5, "R4 drain");
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int c0, p0;
    cpu_write(2'd2, 32'h11);
    c0 = acc_cnt;
    cpu_write(2'd3, 32'd5);
    cpu_read(2'd3, v);
    check("R9 busy set", v, 32'h1);
    cpu_write(2'd3, 32'd6);
    cpu_write(2'd3, 32'd4);
    wait_idle("R10 busy reqs");
    repeat (60) @(negedge clk);
    check("R10 one access only", acc_cnt, c0 + 1);
    cpu_read(2'd2, v);
    check("R10 data unchanged", v, 32'h11);
    cpu_read(2'd3, v);
    check("R9 done flag", v, 32'h2);
    p0 = poll_cnt;
    cpu_write(2'd3, 32'd0);
    repeat (60) @(negedge clk);
    check("R10 op0 no poll", poll_cnt, p0);
    check("R10 op0 no access", acc_cnt, c0 + 1);
    cpu_read(2'd3, v);
    check("R10 op0 not busy", v, 32'h2);
  endtask

  task automatic t_timing();
    check("R7 setup and E width", viol, 0);
    check("R8 bus released", z_viol, 0);
    check("R4 poll before access", order_viol, 0);
    check("R8 idle bus z", {24'h0, lcd_db}, 32'h0000_00zz);
  endtask

  initial begin
    #1_600_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_display();
    t_addr();
    t_write();
    t_read();
    t_busy();
    t_ignore();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule